// File: doc/BRIEF.md
# Configurable valid-ready channel register slice

This block is one pipeline stage placed in a single valid/ready handshake path, such as one address, write-data, read-data or response channel of an on-chip bus. A payload crosses from the source-side port to the destination-side port. A compile-time parameter picks how much timing isolation the stage adds and what throughput it keeps.

There are four variants. A pass-through variant is plain wiring. A two-entry skid variant registers valid, payload and ready and still moves a beat every cycle. A single-register variant costs the least area, but it leaves an idle cycle after each beat. A forward-only variant registers valid and payload, keeps ready combinational from the destination, and runs back-to-back.

A typical setup uses the single-register variant on address and write-response paths and the skid variant on bulk data paths. For a lightweight bus profile the single-register variant is used on every path.

Top module: `chan_slice`

## Requirements
- R1: With MODE = SLICE_PASS (code 0), dst_valid equals src_valid, dst_data equals src_data and src_ready equals dst_ready within the same cycle, with no register on any of them.
- R2: With MODE = SLICE_SKID (code 1), and the source always valid and the destination always ready, a beat reaches the destination on every cycle after the first. This gives 19 deliveries in 20 cycles from an empty stage.
- R3: With MODE = SLICE_SKID, src_ready comes from a flop and does not change within a cycle when dst_ready changes. From empty with dst_ready held low, exactly two beats are accepted before src_ready drops.
- R4: With MODE = SLICE_SINGLE (code 2), src_ready is low in the cycle after any accepted beat. Continuous traffic therefore moves at most one beat every two cycles (10 deliveries in 20 cycles), and one beat is held when the destination stalls.
- R5: With MODE = SLICE_FWD (code 3), src_ready equals dst_ready OR NOT dst_valid in the same cycle. Continuous traffic gives 19 deliveries in 20 cycles, and one beat is held when the destination stalls.
- R6: In every mode, beats leave in the order they were accepted, with none lost and none repeated, under any valid/ready pattern.
- R7: In every registered mode, if dst_valid is high and dst_ready is low at a clock edge, then dst_valid stays high and dst_data is unchanged in the next cycle.
- R8: After synchronous active-low reset, every registered mode holds no beat: dst_valid is low and src_ready is high in the first cycle after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | 1 | Source offers a beat |
| src_ready | output | 1 | Stage can take a beat |
| src_data | input | DATA_W | Source payload |
| dst_valid | output | 1 | Stage offers a beat |
| dst_ready | input | 1 | Destination takes the beat |
| dst_data | output | DATA_W | Payload toward the destination |

## Verification
Pass-through results are due in the same cycle as the stimulus. In the registered variants, a beat accepted at an edge appears at the destination in the cycle that follows, and each change to ready shows up one edge after the state that caused it. The bench drives inputs at the falling edge and samples all outputs 1 ns later. It records each handshake at that sample point, and it advances its expected sequence counters only at the next falling edge, after the rising edge that committed the transfer. To prove that ready is registered, the bench flips dst_ready within a cycle and checks that src_ready does not move before the next edge.

// File: rtl/slice_pkg.sv
// Shared definitions for the channel register slice.
// Assumes: nothing beyond standard SystemVerilog packages.
package slice_pkg;
    // Stage variant selected at elaboration time; codes are fixed.
    typedef enum logic [1:0] {
        SLICE_PASS   = 2'd0,
        SLICE_SKID   = 2'd1,
        SLICE_SINGLE = 2'd2,
        SLICE_FWD    = 2'd3
    } slice_mode_e;
endpackage

// File: rtl/slice_skid.sv
// Two-entry skid stage: valid, payload and ready toward the source all
// come from flops, and a beat can pass on every cycle.
// Assumes: source holds payload while valid and not ready (standard handshake).
module slice_skid #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [DATA_W-1:0] dst_data
);
    logic              out_v, spare_v;
    logic [DATA_W-1:0] out_d, spare_d;
    logic              take, out_free;

    assign src_ready = !spare_v;
    assign dst_valid = out_v;
    assign dst_data  = out_d;
    assign take      = src_valid && !spare_v;
    assign out_free  = !out_v || dst_ready;

    // Occupancy of the output register and the spare entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v   <= 1'b0;
            spare_v <= 1'b0;
        end else if (out_free) begin
            if (spare_v) begin
                out_v   <= 1'b1;
                spare_v <= 1'b0;
            end else begin
                out_v <= take;
            end
        end else if (take) begin
            spare_v <= 1'b1;
        end
    end

    // Payload steering: refill output from spare first, else from source.
    always_ff @(posedge clk) begin
        if (out_free) begin
            if (spare_v)   out_d <= spare_d;
            else if (take) out_d <= src_data;
        end
        if (!out_free && take) spare_d <= src_data;
    end

    // R7
    skid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));
    // R3
    skid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ready |-> dst_valid);
    // R2
    skid_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> dst_valid);
    // R8
    skid_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dst_valid && src_ready));
endmodule

// File: rtl/slice_single.sv
// Single-register stage: one payload register with a full flag. It takes
// a beat only while empty, so an idle cycle follows each beat.
// Assumes: standard valid/ready handshake on both sides.
module slice_single #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [DATA_W-1:0] dst_data
);
    logic              full;
    logic [DATA_W-1:0] hold_d;

    assign src_ready = !full;
    assign dst_valid = full;
    assign dst_data  = hold_d;

    // Full flag: fill when empty and offered, drain when accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                 full <= 1'b0;
        else if (full && dst_ready) full <= 1'b0;
        else if (!full && src_valid) full <= 1'b1;
    end

    // Payload capture on fill.
    always_ff @(posedge clk) begin
        if (!full && src_valid) hold_d <= src_data;
    end

    // R4
    single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> !src_ready);
    // R7
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));
    // R8
    single_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dst_valid && src_ready));
endmodule

// File: rtl/slice_fwd.sv
// Forward-only stage: valid and payload registered, ready toward the
// source combinational from the destination ready and the output state.
// Assumes: the ready path through this stage meets timing on its own.
module slice_fwd #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [DATA_W-1:0] dst_data
);
    logic              out_v;
    logic [DATA_W-1:0] out_d;

    assign src_ready = !out_v || dst_ready;
    assign dst_valid = out_v;
    assign dst_data  = out_d;

    // Output valid reloads whenever the register is free or being drained.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_v <= 1'b0;
        else if (src_ready) out_v <= src_valid;
    end

    // Payload capture on accepted beat.
    always_ff @(posedge clk) begin
        if (src_ready && src_valid) out_d <= src_data;
    end

    // R5
    fwd_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> (dst_valid && dst_data == $past(src_data)));
    // R7
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));
    // R8
    fwd_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dst_valid && src_ready));
endmodule

// File: rtl/chan_slice.sv
// Channel register slice top: picks one stage variant by MODE.
// Assumes: MODE is fixed at elaboration; rst_n is synchronous, active low.
module chan_slice #(
    parameter int                    DATA_W = 32,
    parameter slice_pkg::slice_mode_e MODE  = slice_pkg::SLICE_SINGLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [DATA_W-1:0] dst_data
);
    // Variant selection; the pass-through branch is plain wiring (R1).
    generate
        case (MODE)
            slice_pkg::SLICE_PASS: begin : g_pass
                assign dst_valid = src_valid;
                assign dst_data  = src_data;
                assign src_ready = dst_ready;
            end
            slice_pkg::SLICE_SKID: begin : g_skid
                slice_skid #(.DATA_W(DATA_W)) u_stage (
                    .clk(clk), .rst_n(rst_n),
                    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
                    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data));
            end
            slice_pkg::SLICE_FWD: begin : g_fwd
                slice_fwd #(.DATA_W(DATA_W)) u_stage (
                    .clk(clk), .rst_n(rst_n),
                    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
                    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data));
            end
            default: begin : g_single
                slice_single #(.DATA_W(DATA_W)) u_stage (
                    .clk(clk), .rst_n(rst_n),
                    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
                    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data));
            end
        endcase
    endgenerate
endmodule

// File: tb/chan_slice_test.sv
`timescale 1ns/1ps
// Bench: all four variants side by side under identical stimulus, with a
// sequence-number scoreboard per variant and periodic pattern sweeps.
module chan_slice_test;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] sv, sr, dv, dr;
    logic [3:0][W-1:0] sd, dd;

    int vectors = 0, miss = 0;
    int tx[4], rx[4], fires[4], accs[4];
    logic [3:0] p_tx, p_rx, prev_stall, prev_acc;
    logic [3:0][W-1:0] prev_data;

    always #5 clk = ~clk;

    for (genvar m = 0; m < 4; m++) begin : g_mode
        chan_slice #(.DATA_W(W), .MODE(slice_pkg::slice_mode_e'(m))) uut (
            .clk(clk), .rst_n(rst_n),
            .src_valid(sv[m]), .src_ready(sr[m]), .src_data(sd[m]),
            .dst_valid(dv[m]), .dst_ready(dr[m]), .dst_data(dd[m]));
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sv = '0; dr = '0;
        for (int m = 0; m < 4; m++) begin
            tx[m] = 0; rx[m] = 0; fires[m] = 0; accs[m] = 0; sd[m] = '0;
        end
        p_tx = '0; p_rx = '0; prev_stall = '0; prev_acc = '0; prev_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int m = 1; m < 4; m++) begin
            chk(dv[m] == 1'b0, $sformatf("R8 mode%0d dst_valid", m), dv[m], 0);
            chk(sr[m] == 1'b1, $sformatf("R8 mode%0d src_ready", m), sr[m], 1);
        end
    endtask

    // One cycle: commit last cycle's handshakes, drive, sample, check.
    task automatic step(input logic [3:0] v, input logic [3:0] r);
        logic [3:0] keep;
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            if (p_tx[m]) tx[m]++;
            if (p_rx[m]) rx[m]++;
            sd[m] = tx[m][W-1:0];
        end
        sv = v; dr = r;
        #1;
        keep = sr;
        dr = ~r;
        #1;
        chk(sr[1] == keep[1], "R3 skid ready moved within cycle", sr[1], keep[1]);
        dr = r;
        #1;
        for (int m = 0; m < 4; m++) begin
            logic acc, fire;
            acc  = sv[m] && sr[m];
            fire = dv[m] && dr[m];
            if (fire)
                chk(dd[m] == tx_exp(m), $sformatf("R6 mode%0d order", m), dd[m], tx_exp(m));
            if (m == 0)
                chk(dv[0] == sv[0] && dd[0] == sd[0] && sr[0] == dr[0],
                    "R1 pass wiring", {dv[0], sr[0]}, {sv[0], dr[0]});
            if (m == 3)
                chk(sr[3] == (dr[3] || !dv[3]), "R5 fwd ready", sr[3], dr[3] || !dv[3]);
            if (m != 0 && prev_stall[m])
                chk(dv[m] && dd[m] == prev_data[m], $sformatf("R7 mode%0d hold", m),
                    dd[m], prev_data[m]);
            if (m == 2 && prev_acc[m])
                chk(!sr[2], "R4 single gap", sr[2], 0);
            p_tx[m] = acc; p_rx[m] = fire;
            prev_stall[m] = dv[m] && !dr[m];
            prev_data[m]  = dd[m];
            prev_acc[m]   = acc;
            fires[m] += fire; accs[m] += acc;
        end
    endtask

    function automatic int tx_exp(input int m);
        return rx[m] % (1 << W);
    endfunction

    task automatic drain_and_count(input string tag);
        repeat (6) step(4'b0000, 4'b1111);
        step(4'b0000, 4'b1111);
        for (int m = 0; m < 4; m++)
            chk(tx[m] == rx[m], $sformatf("R6 mode%0d %s no loss", m, tag), rx[m], tx[m]);
    endtask

    initial begin
        int exp_thr[4], exp_hold[4];
        exp_thr  = '{20, 19, 10, 19};
        exp_hold = '{0, 2, 1, 1};
        sv = '0; dr = '0; sd = '0;

        // R2 R4 R5: sustained throughput from empty.
        do_reset();
        for (int m = 0; m < 4; m++) fires[m] = 0;
        repeat (20) step(4'b1111, 4'b1111);
        chk(fires[0] == exp_thr[0], "R1 pass rate", fires[0], exp_thr[0]);
        chk(fires[1] == exp_thr[1], "R2 skid rate", fires[1], exp_thr[1]);
        chk(fires[2] == exp_thr[2], "R4 single rate", fires[2], exp_thr[2]);
        chk(fires[3] == exp_thr[3], "R5 fwd rate", fires[3], exp_thr[3]);
        drain_and_count("rate");

        // R3 R4 R5: beats absorbed while destination stalls.
        do_reset();
        repeat (6) step(4'b1111, 4'b0000);
        for (int m = 0; m < 4; m++)
            chk(accs[m] == exp_hold[m], $sformatf("R3 mode%0d stall capacity", m),
                accs[m], exp_hold[m]);
        drain_and_count("stall");

        // R6 R7: sweep all 4-cycle periodic valid and ready patterns.
        do_reset();
        for (int vp = 0; vp < 16; vp++) begin
            for (int rp = 0; rp < 16; rp++) begin
                for (int c = 0; c < 16; c++) begin
                    logic vb, rb;
                    vb = vp[c % 4];
                    rb = rp[(c + vp) % 4];
                    step({4{vb}}, {4{rb}});
                end
            end
        end
        drain_and_count("sweep");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        #1_500_000;
        vectors++; miss++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end
endmodule